// File: doc/BRIEF.md
# Infrared Remote Carrier Generator

This block drives the single transmit pin of an infrared remote control. A one-bit data level from the controller switches the pin on and off, and a two-bit mode register chooses the waveform seen while the level is high. Three of the four modes chop the level with a carrier cut from an internal clock: a divide-by-12 carrier with a short duty, a divide-by-12 carrier with a longer duty, and a divide-by-8 square wave. The fourth mode sends the data level to the pin with no carrier.

The internal clock is either the system clock itself or the system clock divided by eight. A static strap input picks one or the other. Each rise of the data level restarts the prescaler and the carrier counter, so every burst opens with a complete high phase. A mode written by software is held pending and only takes over when the running carrier period closes, or when a new burst starts. This keeps shortened pulses off the pin. The pin is driven from a register.

Top module: `ircar_gen`

## Requirements
- R1: A synchronous reset drives `rem_out` low and makes mode 00 the active mode. The first burst after reset therefore uses the 00 waveform.
- R2: With `strap_slow` = 0 one carrier step lasts one clock. With `strap_slow` = 1 one carrier step lasts eight clocks, and every high and low phase is stretched by eight.
- R3: Mode 00, with the data level held high, repeats a 12-step period with the pin high for the first 3 steps.
- R4: Mode 01, with the data level held high, repeats a 12-step period with the pin high for the first 4 steps.
- R5: Mode 10, with the data level held high, repeats an 8-step period with the pin high for the first 4 steps.
- R6: In mode 11, `rem_out` equals the `tx_bit` value from the previous clock. This holds for either strap setting.
- R7: In a carrier mode, a low `tx_bit` makes `rem_out` low on the next clock and keeps it low, even in the middle of a high phase.
- R8: A rising `tx_bit` restarts the prescaler and the carrier counter. `rem_out` is high on the next clock and stays high for a full high phase, even when the rise falls inside an earlier period.
- R9: A mode written through `mode_we`/`mode_wdata` does not change the running period. It becomes active only at the end of that period or at the next rise of `tx_bit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| strap_slow | input | 1 | Static strap: 0 selects clk as the internal clock, 1 selects clk/8 |
| mode_we | input | 1 | Write strobe for the pending mode |
| mode_wdata | input | 2 | Mode value: 00, 01, 10 carrier modes, 11 no carrier |
| tx_bit | input | 1 | Output data level from software |
| rem_out | output | 1 | Registered transmit pin |

## Verification
The hardest case to reach is a mode write that arrives while a burst is running and the carrier is partway through a period. The pin must finish the old period exactly and only then switch to the new waveform. The bench starts a mode-00 burst, writes mode 10 during the low phase of the first period, and compares every following clock against a pattern made of one full 12-step period and then the 8-step square wave. A second hard case is a new rise in the middle of a period. The bench creates it by dropping `tx_bit` during the low phase and raising it again, then checks that a complete high phase follows.

// File: rtl/ircar_pkg.sv
package ircar_pkg;
  timeunit 1ns; timeprecision 1ps;

  typedef enum logic [1:0] {
    CAR_QTR  = 2'b00,
    CAR_TRD  = 2'b01,
    CAR_HALF = 2'b10,
    CAR_OFF  = 2'b11
  } car_mode_e;

  localparam int CNT_W = 4;

  // final step index of one carrier period
  function automatic logic [CNT_W-1:0] last_step(car_mode_e m);
    case (m)
      CAR_QTR, CAR_TRD: last_step = CNT_W'(11);
      CAR_HALF:         last_step = CNT_W'(7);
      default:          last_step = CNT_W'(0);
    endcase
  endfunction

  // number of leading high steps in one period
  function automatic logic [CNT_W-1:0] high_steps(car_mode_e m);
    case (m)
      CAR_QTR:  high_steps = CNT_W'(3);
      CAR_TRD:  high_steps = CNT_W'(4);
      CAR_HALF: high_steps = CNT_W'(4);
      default:  high_steps = CNT_W'(1);
    endcase
  endfunction

  function automatic logic carrier_level(car_mode_e m, logic [CNT_W-1:0] step);
    carrier_level = (step < high_steps(m));
  endfunction
endpackage

// File: rtl/ircar_prescale.sv
module ircar_prescale #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic slow_sel,
  input  logic restart,
  output logic tick
);
  timeunit 1ns; timeprecision 1ps;

  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] TOP = PW'(DIV - 1);

  logic [PW-1:0] pre;

  always_ff @(posedge clk) begin
    if (rst || restart || !slow_sel) pre <= '0;
    else if (pre == TOP)             pre <= '0;
    else                             pre <= pre + PW'(1);
  end

  assign tick = !slow_sel || (pre == TOP);
endmodule

// File: rtl/ircar_divider.sv
module ircar_divider
  import ircar_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick,
  input  logic                 restart,
  input  car_mode_e            pend_mode,
  output car_mode_e            act_mode,
  output logic                 wrap,
  output car_mode_e            mode_nx,
  output logic [CNT_W-1:0]     step_nx
);
  timeunit 1ns; timeprecision 1ps;

  logic [CNT_W-1:0] step;

  assign wrap = tick && (step == last_step(act_mode));

  always_comb begin
    mode_nx = act_mode;
    step_nx = step;
    if (restart || wrap) begin
      mode_nx = pend_mode;
      step_nx = '0;
    end else if (tick) begin
      step_nx = step + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      step     <= '0;
      act_mode <= CAR_QTR;
    end else begin
      step     <= step_nx;
      act_mode <= mode_nx;
    end
  end
endmodule

// File: rtl/ircar_gen.sv
module ircar_gen
  import ircar_pkg::*;
#(
  parameter int PRESCALE = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       strap_slow,
  input  logic       mode_we,
  input  logic [1:0] mode_wdata,
  input  logic       tx_bit,
  output logic       rem_out
);
  timeunit 1ns; timeprecision 1ps;

  car_mode_e        pend_mode;
  car_mode_e        act_mode;
  car_mode_e        mode_nx;
  logic [CNT_W-1:0] step_nx;
  logic             tx_q;
  logic             restart;
  logic             tick;
  logic             wrap;
  logic             rem_q;

  assign restart = tx_bit && !tx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_mode <= CAR_QTR;
      tx_q      <= 1'b0;
      rem_q     <= 1'b0;
    end else begin
      if (mode_we) pend_mode <= car_mode_e'(mode_wdata);
      tx_q  <= tx_bit;
      rem_q <= tx_bit && carrier_level(mode_nx, step_nx);
    end
  end

  ircar_prescale #(.DIV(PRESCALE)) u_pre (
    .clk      (clk),
    .rst      (rst),
    .slow_sel (strap_slow),
    .restart  (restart),
    .tick     (tick)
  );

  ircar_divider u_div (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .restart   (restart),
    .pend_mode (pend_mode),
    .act_mode  (act_mode),
    .wrap      (wrap),
    .mode_nx   (mode_nx),
    .step_nx   (step_nx)
  );

  assign rem_out = rem_q;
endmodule

// File: rtl/ircar_chk.sv
module ircar_chk (
  input logic       clk,
  input logic       rst,
  input logic       strap_slow,
  input logic       tx_bit,
  input logic       rem_out,
  input logic       tick,
  input logic       restart,
  input logic       wrap,
  input logic [1:0] act_mode
);
  timeunit 1ns; timeprecision 1ps;

  a_r1_reset_low: assert property (@(posedge clk) rst |=> !rem_out);

  a_r2_slow_spacing: assert property (@(posedge clk) disable iff (rst)
    (strap_slow && tick) |=> (!tick || !strap_slow));

  a_r6_bypass_follows: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && act_mode == 2'b11) |-> (rem_out == $past(tx_bit)));

  a_r7_idle_low: assert property (@(posedge clk) disable iff (rst)
    !tx_bit |=> !rem_out);

  a_r8_burst_opens_high: assert property (@(posedge clk) disable iff (rst)
    restart |=> rem_out);

  a_r9_switch_on_boundary: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && act_mode != $past(act_mode)) |-> $past(wrap || restart));
endmodule

bind ircar_gen ircar_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .strap_slow (strap_slow),
  .tx_bit     (tx_bit),
  .rem_out    (rem_out),
  .tick       (tick),
  .restart    (restart),
  .wrap       (wrap),
  .act_mode   (act_mode)
);

// File: tb/ircar_gen_test.sv
module ircar_gen_test;
  timeunit 1ns; timeprecision 1ps;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       strap_slow = 1'b0;
  logic       mode_we = 1'b0;
  logic [1:0] mode_wdata = 2'b00;
  logic       tx_bit = 1'b1;
  logic       rem_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ircar_gen uut (
    .clk        (clk),
    .rst        (rst),
    .strap_slow (strap_slow),
    .mode_we    (mode_we),
    .mode_wdata (mode_wdata),
    .tx_bit     (tx_bit),
    .rem_out    (rem_out)
  );

  // {strap, mode, period steps, high steps}
  localparam logic [10:0] VEC [6] = '{
    {1'b0, 2'd0, 4'd12, 4'd3},
    {1'b0, 2'd1, 4'd12, 4'd4},
    {1'b0, 2'd2, 4'd8,  4'd4},
    {1'b1, 2'd0, 4'd12, 4'd3},
    {1'b1, 2'd1, 4'd12, 4'd4},
    {1'b1, 2'd2, 4'd8,  4'd4}
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic string vec_tag(input logic s, input logic [1:0] m);
    string t;
    case (m)
      2'd0:    t = "R3 mode00";
      2'd1:    t = "R4 mode01";
      default: t = "R5 mode10";
    endcase
    if (s) t = {t, " R2 slow"};
    return t;
  endfunction

  task automatic wr_mode(input logic [1:0] m);
    @(negedge clk);
    mode_we = 1'b1;
    mode_wdata = m;
    @(negedge clk);
    mode_we = 1'b0;
  endtask

  task automatic idle(input int n);
    tx_bit = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state with the data level already high
    repeat (3) @(negedge clk);
    chk("R1 reset output", rem_out, 0);
    rst = 1'b0;
    // R1: default mode 00 after reset, fast strap
    for (int j = 0; j < 24; j++) begin
      @(negedge clk);
      chk("R1 default mode00", rem_out, (j % 12) < 3);
    end

    // R2 R3 R4 R5: table walk
    for (int v = 0; v < 6; v++) begin
      logic       s;
      logic [1:0] m;
      int per, hi, dv;
      s   = VEC[v][10];
      m   = VEC[v][9:8];
      per = int'(VEC[v][7:4]);
      hi  = int'(VEC[v][3:0]);
      dv  = s ? 8 : 1;
      idle(4);
      strap_slow = s;
      wr_mode(m);
      tx_bit = 1'b1;
      for (int j = 0; j < 3 * per * dv; j++) begin
        @(negedge clk);
        chk(vec_tag(s, m), rem_out, ((j / dv) % per) < hi);
      end
    end

    // R7: drop data inside a high phase
    idle(4);
    strap_slow = 1'b0;
    wr_mode(2'd2);
    tx_bit = 1'b1;
    for (int j = 0; j < 2; j++) begin
      @(negedge clk);
      chk("R7 high before drop", rem_out, 1);
    end
    tx_bit = 1'b0;
    for (int j = 0; j < 10; j++) begin
      @(negedge clk);
      chk("R7 idle low", rem_out, 0);
    end

    // R8: re-rise in the middle of a period
    wr_mode(2'd0);
    tx_bit = 1'b1;
    for (int j = 0; j < 6; j++) begin
      @(negedge clk);
      chk("R8 first burst", rem_out, j < 3);
    end
    tx_bit = 1'b0;
    repeat (2) @(negedge clk);
    tx_bit = 1'b1;
    for (int j = 0; j < 14; j++) begin
      @(negedge clk);
      chk("R8 restart full high", rem_out, (j % 12) < 3);
    end

    // R9: mode write during a running period
    idle(15);
    wr_mode(2'd0);
    tx_bit = 1'b1;
    for (int j = 0; j < 36; j++) begin
      @(negedge clk);
      chk("R9 boundary switch", rem_out, (j < 12) ? (j < 3) : (((j - 12) % 8) < 4));
      if (j == 4) begin
        mode_we = 1'b1;
        mode_wdata = 2'd2;
      end
      if (j == 5) mode_we = 1'b0;
    end

    // R6: no-carrier bypass, both strap settings
    for (int s = 0; s < 2; s++) begin
      logic [11:0] pat;
      pat = 12'b1011_0011_1010;
      idle(4);
      strap_slow = s[0];
      wr_mode(2'd3);
      idle(20);
      for (int i = 0; i < 12; i++) begin
        tx_bit = pat[i];
        @(negedge clk);
        chk("R6 bypass", rem_out, pat[i]);
      end
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule